// File: doc/BRIEF.md
# Power-Down Mode Controller

This block takes a low-power request that the processor writes into its control/status word and turns it into clock-enable outputs. The outputs go to the CPU core, the interrupt logic, the memory-transfer path, the PLL output stage and the PLL reference input. It holds the current sleep depth and decides when to wake. The two light sleeps end on interrupt activity: one waits for an interrupt that is pending and enabled, the other for any pending interrupt. The two deep sleeps stop the clock tree, and only a device reset ends them.

Every reset is treated as a possible exit from the deepest mode, where the PLL reference was stopped. After reset release, a programmable relock wait runs before clocks are handed back to the chip. While that wait runs, an indicator output stays low. In both deep modes the block raises a hold output, which tells the surrounding logic to freeze register, RAM and I/O state.

Top module: `pwrdn_ctrl`

## Requirements
- R1: When `rst_n` rises, `clk_rel` stays 0 through the next `relock_cycles`+2 rising edges. It becomes 1 after edge number `relock_cycles`+3, which covers a two-stage reset synchronizer and a wait of `relock_cycles`+1 cycles. During the wait only `pll_ref_en` is 1 and `mode_rd` is 0. After the wait the block is running and all enables are 1.
- R2: The mode field is bits 15:10 of `csr_wdata`. While running, a write stores that field, and `mode_rd` shows it after the write edge. A field of 0, or of any value other than 0x09, 0x11, 0x1A or 0x1C, leaves every enable at 1. Bits of `csr_wdata` outside 15:10 have no effect.
- R3: Code 0x09 (enabled-wake sleep) sets `cpu_clk_en` to 0 and keeps `irq_clk_en`, `dma_clk_en`, `pll_out_en` and `pll_ref_en` at 1. It ends at the first edge where `irq_pend & irq_en` is nonzero. Pending lines whose enable bit is 0 do not wake it.
- R4: Code 0x11 (any-wake sleep) uses the same enables as R3. It ends at the first edge where `irq_pend` is nonzero, whatever the value of `irq_en`.
- R5: When either light sleep wakes, the block returns to running with all enables at 1, and `mode_rd` reads 0 from that edge on.
- R6: Code 0x1A (output halt) sets `cpu_clk_en`, `irq_clk_en`, `dma_clk_en` and `pll_out_en` to 0 and keeps `pll_ref_en` at 1. Interrupts and writes do not end it; only `rst_n` low does.
- R7: Code 0x1C (reference stop) is R6 with `pll_ref_en` also 0. Only `rst_n` low ends it, and the exit includes the relock wait of R1.
- R8: In every sleep state a write has no effect: `mode_rd` and the enables stay unchanged.
- R9: `io_hold` is 1 exactly in the two deep modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running always-on clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| csr_wr | input | 1 | Write strobe for the control/status word |
| csr_wdata | input | 32 | Written word; mode field in bits 15:10 |
| relock_cycles | input | RELOCK_W | Relock wait length, held stable while it runs |
| irq_pend | input | IRQ_W | Pending interrupt lines |
| irq_en | input | IRQ_W | Per-line interrupt enable mask |
| mode_rd | output | 6 | Current mode field |
| cpu_clk_en | output | 1 | CPU core clock enable |
| irq_clk_en | output | 1 | Interrupt logic clock enable |
| dma_clk_en | output | 1 | Peripheral/internal memory transfer clock enable |
| pll_out_en | output | 1 | PLL output clock enable |
| pll_ref_en | output | 1 | PLL reference input enable |
| clk_rel | output | 1 | Relock wait finished, clocks released |
| io_hold | output | 1 | Freeze registers, RAM and I/O (deep modes) |

## Verification
The assertions assume that `relock_cycles` does not change while a relock wait is running. The counter bound check depends on this. The bench picks a new value only while `rst_n` is held low. The assertions also assume that the deep modes are left only through `rst_n`, so the bench drives a reset whenever its random sequence has stayed in a deep mode for a few cycles. The random write data fills the bits outside 15:10 freely, and the codes are weighted toward the four defined values so that every sleep state is reached often.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  localparam int MODE_W   = 6;
  localparam int MODE_LSB = 10;

  localparam logic [MODE_W-1:0] CODE_NONE     = 6'h00;
  localparam logic [MODE_W-1:0] CODE_LS_EN    = 6'h09;
  localparam logic [MODE_W-1:0] CODE_LS_ANY   = 6'h11;
  localparam logic [MODE_W-1:0] CODE_DEEP_OUT = 6'h1A;
  localparam logic [MODE_W-1:0] CODE_DEEP_REF = 6'h1C;

  typedef enum logic [2:0] {
    ST_RELOCK   = 3'd0,
    ST_RUN      = 3'd1,
    ST_LS_EN    = 3'd2,
    ST_LS_ANY   = 3'd3,
    ST_DEEP_OUT = 3'd4,
    ST_DEEP_REF = 3'd5
  } pd_state_e;

  typedef struct packed {
    logic cpu;
    logic irq;
    logic dma;
    logic pll_out;
    logic pll_ref;
    logic rel;
    logic hold;
  } gate_t;

  function automatic pd_state_e code_to_state(input logic [MODE_W-1:0] code);
    case (code)
      CODE_LS_EN:    return ST_LS_EN;
      CODE_LS_ANY:   return ST_LS_ANY;
      CODE_DEEP_OUT: return ST_DEEP_OUT;
      CODE_DEEP_REF: return ST_DEEP_REF;
      default:       return ST_RUN;
    endcase
  endfunction

  function automatic logic is_sleep(input pd_state_e s);
    return (s == ST_LS_EN) || (s == ST_LS_ANY) ||
           (s == ST_DEEP_OUT) || (s == ST_DEEP_REF);
  endfunction

endpackage

// File: rtl/pwrdn_rst_sync.sv
module pwrdn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pwrdn_wake.sv
module pwrdn_wake #(
  parameter int IRQ_W = 16
) (
  input  logic [IRQ_W-1:0] irq_pend,
  input  logic [IRQ_W-1:0] irq_en,
  output logic             any_pend,
  output logic             en_pend
);

  logic [IRQ_W-1:0] masked;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_mask
    assign masked[i] = irq_pend[i] & irq_en[i];
  end

  assign any_pend = |irq_pend;
  assign en_pend  = |masked;

endmodule

// File: rtl/pwrdn_relock.sv
module pwrdn_relock #(
  parameter int RELOCK_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic [RELOCK_W-1:0] limit,
  output logic                done
);

  logic [RELOCK_W-1:0] cnt_q;
  logic [RELOCK_W-1:0] cnt_d;
  logic                cnt_ce;

  always_comb begin
    cnt_ce = active && (cnt_q != limit);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign done = active && (cnt_q == limit);

  AST_RELOCK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= limit)) else $error("relock count passed limit"); // R1

endmodule

// File: rtl/pwrdn_gates.sv
module pwrdn_gates
  import pwrdn_pkg::*;
(
  input  pd_state_e state,
  output gate_t     gates
);

  always_comb begin
    gates = '0;
    case (state)
      ST_RELOCK: begin
        gates.pll_ref = 1'b1;
      end
      ST_RUN: begin
        gates = '1;
        gates.hold = 1'b0;
      end
      ST_LS_EN, ST_LS_ANY: begin
        gates.irq     = 1'b1;
        gates.dma     = 1'b1;
        gates.pll_out = 1'b1;
        gates.pll_ref = 1'b1;
        gates.rel     = 1'b1;
      end
      ST_DEEP_OUT: begin
        gates.pll_ref = 1'b1;
        gates.rel     = 1'b1;
        gates.hold    = 1'b1;
      end
      ST_DEEP_REF: begin
        gates.rel     = 1'b1;
        gates.hold    = 1'b1;
      end
      default: gates = '0;
    endcase
  end

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int IRQ_W    = 16,
  parameter int RELOCK_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_wr,
  input  logic [31:0]         csr_wdata,
  input  logic [RELOCK_W-1:0] relock_cycles,
  input  logic [IRQ_W-1:0]    irq_pend,
  input  logic [IRQ_W-1:0]    irq_en,
  output logic [5:0]          mode_rd,
  output logic                cpu_clk_en,
  output logic                irq_clk_en,
  output logic                dma_clk_en,
  output logic                pll_out_en,
  output logic                pll_ref_en,
  output logic                clk_rel,
  output logic                io_hold
);

  localparam int MODE_MSB = MODE_LSB + MODE_W - 1;

  logic              rst_int_n;
  logic              any_pend;
  logic              en_pend;
  logic              relock_done;
  pd_state_e         st_q, st_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              st_ce, mode_ce;
  logic [MODE_W-1:0] wr_field;
  gate_t             gates;

  pwrdn_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  pwrdn_wake #(.IRQ_W(IRQ_W)) u_wake (
    .irq_pend (irq_pend),
    .irq_en   (irq_en),
    .any_pend (any_pend),
    .en_pend  (en_pend)
  );

  pwrdn_relock #(.RELOCK_W(RELOCK_W)) u_relock (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .active (st_q == ST_RELOCK),
    .limit  (relock_cycles),
    .done   (relock_done)
  );

  assign wr_field = csr_wdata[MODE_MSB:MODE_LSB];

  // next-state logic
  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    case (st_q)
      ST_RELOCK: begin
        if (relock_done) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (csr_wr) begin
          mode_d = wr_field;
          st_d   = code_to_state(wr_field);
        end
      end
      ST_LS_EN: begin
        if (en_pend) begin
          st_d   = ST_RUN;
          mode_d = CODE_NONE;
        end
      end
      ST_LS_ANY: begin
        if (any_pend) begin
          st_d   = ST_RUN;
          mode_d = CODE_NONE;
        end
      end
      default: begin
        st_d   = st_q;
        mode_d = mode_q;
      end
    endcase
    st_ce   = (st_d != st_q);
    mode_ce = (mode_d != mode_q);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  st_q <= ST_RELOCK;
    else if (st_ce)  st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   mode_q <= CODE_NONE;
    else if (mode_ce) mode_q <= mode_d;
  end

  pwrdn_gates u_gates (
    .state (st_q),
    .gates (gates)
  );

  assign mode_rd    = mode_q;
  assign cpu_clk_en = gates.cpu;
  assign irq_clk_en = gates.irq;
  assign dma_clk_en = gates.dma;
  assign pll_out_en = gates.pll_out;
  assign pll_ref_en = gates.pll_ref;
  assign clk_rel    = gates.rel;
  assign io_hold    = gates.hold;

  AST_REL_ONLY_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_RELOCK) |-> (!clk_rel && !cpu_clk_en && mode_q == CODE_NONE)) else $error("clock released during relock"); // R1

  AST_UNDEF_STAYS_RUN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_RUN && csr_wr && code_to_state(wr_field) == ST_RUN) |=> (st_q == ST_RUN && cpu_clk_en)) else $error("undefined code slept"); // R2

  AST_LS_EN_WAKE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_LS_EN && en_pend) |=> (st_q == ST_RUN && mode_q == CODE_NONE)) else $error("enabled wake missed"); // R3

  AST_LS_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_LS_EN && !en_pend) |=> (st_q == ST_LS_EN)) else $error("woke without enabled irq"); // R3

  AST_LS_ANY_WAKE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_LS_ANY && any_pend) |=> (st_q == ST_RUN && cpu_clk_en)) else $error("any-wake missed"); // R4

  AST_LS_TRANSFERS_ON: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_LS_EN || st_q == ST_LS_ANY) |-> (dma_clk_en && irq_clk_en && !cpu_clk_en)) else $error("light sleep gating"); // R3

  AST_DEEP_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_DEEP_OUT || st_q == ST_DEEP_REF) |=> ($stable(st_q) && $stable(mode_q))) else $error("deep mode left"); // R6

  AST_SLEEP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (is_sleep(st_q) && csr_wr && !any_pend) |=> $stable(mode_q)) else $error("write in sleep"); // R8

  AST_REF_OFF_DEEPEST: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pll_ref_en |-> (st_q == ST_DEEP_REF)) else $error("reference off outside deepest"); // R7

  AST_HOLD_DEEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    io_hold |-> (!cpu_clk_en && !dma_clk_en && !pll_out_en)) else $error("hold with clocks"); // R9

endmodule

// File: tb/pwrdn_ctrl_bench.sv
`timescale 1ns/1ps
module pwrdn_ctrl_bench;

  localparam int IRQ_W    = 16;
  localparam int RELOCK_W = 12;

  localparam int M_RELOCK = 0, M_RUN = 1, M_LSE = 2, M_LSA = 3, M_DOUT = 4, M_DREF = 5;

  logic                clk;
  logic                rst_n;
  logic                csr_wr;
  logic [31:0]         csr_wdata;
  logic [RELOCK_W-1:0] relock_cycles;
  logic [IRQ_W-1:0]    irq_pend;
  logic [IRQ_W-1:0]    irq_en;
  logic [5:0]          mode_rd;
  logic cpu_clk_en, irq_clk_en, dma_clk_en, pll_out_en, pll_ref_en, clk_rel, io_hold;

  int checks = 0;
  int errors = 0;

  int          m_st;
  int          m_sync;
  int          m_cnt;
  logic [5:0]  m_mode;

  pwrdn_ctrl #(.IRQ_W(IRQ_W), .RELOCK_W(RELOCK_W)) u_pwrdn_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .relock_cycles(relock_cycles), .irq_pend(irq_pend), .irq_en(irq_en),
    .mode_rd(mode_rd), .cpu_clk_en(cpu_clk_en), .irq_clk_en(irq_clk_en),
    .dma_clk_en(dma_clk_en), .pll_out_en(pll_out_en), .pll_ref_en(pll_ref_en),
    .clk_rel(clk_rel), .io_hold(io_hold)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // expected enables {cpu,irq,dma,pll_out,pll_ref,rel,hold}
  function automatic logic [6:0] exp_gates(input int st);
    case (st)
      M_RELOCK: return 7'b0000100;
      M_RUN:    return 7'b1111110;
      M_LSE, M_LSA: return 7'b0111110;
      M_DOUT:   return 7'b0000111;
      M_DREF:   return 7'b0000011;
      default:  return 7'b0000000;
    endcase
  endfunction

  function automatic int code_state(input logic [5:0] c);
    case (c)
      6'h09: return M_LSE;
      6'h11: return M_LSA;
      6'h1A: return M_DOUT;
      6'h1C: return M_DREF;
      default: return M_RUN;
    endcase
  endfunction

  function automatic string st_tag(input int st);
    case (st)
      M_RELOCK: return "R1";
      M_RUN:    return "R2";
      M_LSE:    return "R3";
      M_LSA:    return "R4";
      M_DOUT:   return "R6";
      default:  return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (m_sync < 2) begin
      m_sync++;
    end else begin
      case (m_st)
        M_RELOCK: if (m_cnt == int'(relock_cycles)) m_st = M_RUN; else m_cnt++;
        M_RUN: if (csr_wr) begin
          m_mode = csr_wdata[15:10];
          m_st   = code_state(csr_wdata[15:10]);
        end
        M_LSE: if ((irq_pend & irq_en) != '0) begin m_st = M_RUN; m_mode = 6'h00; end
        M_LSA: if (irq_pend != '0) begin m_st = M_RUN; m_mode = 6'h00; end
        default: ;
      endcase
    end
  endtask

  task automatic compare_all();
    check(st_tag(m_st),
          {19'd0, mode_rd, cpu_clk_en, irq_clk_en, dma_clk_en, pll_out_en, pll_ref_en, clk_rel, io_hold},
          {19'd0, m_mode, exp_gates(m_st)});
  endtask

  // called just after a negedge: drive, take one edge, compare at next negedge
  task automatic step(input logic wr, input logic [31:0] data,
                      input logic [IRQ_W-1:0] pend, input logic [IRQ_W-1:0] en);
    csr_wr = wr; csr_wdata = data; irq_pend = pend; irq_en = en;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset(input logic [RELOCK_W-1:0] rl);
    rst_n = 1'b0;
    csr_wr = 1'b0; irq_pend = '0;
    relock_cycles = rl;
    m_st = M_RELOCK; m_sync = 0; m_cnt = 0; m_mode = 6'h00;
    repeat (3) @(negedge clk);
    compare_all();
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] wr_word(input logic [5:0] code);
    logic [31:0] w;
    w = $urandom;
    w[15:10] = code;
    return w;
  endfunction

  initial begin : watchdog
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1F2E3D4C));
    csr_wr = 1'b0; csr_wdata = '0; irq_pend = '0; irq_en = '0;
    relock_cycles = '0; rst_n = 1'b0;
    @(negedge clk);

    // R1: directed relock timing with wait length 5
    do_reset(12'd5);
    for (int i = 0; i < 7; i++) begin
      step(1'b0, '0, '0, '0);
      check("R1 clk_rel low during wait", {31'd0, clk_rel}, 32'd0);
    end
    step(1'b0, '0, '0, '0);
    check("R1 clk_rel high after wait", {31'd0, clk_rel}, 32'd1);

    // R2: field outside 15:10 has no effect
    step(1'b1, 32'h0000_0009, '0, '0);
    check("R2 low bits ignored", {31'd0, cpu_clk_en}, 32'd1);
    step(1'b1, wr_word(6'h2A), '0, '0);
    check("R2 undefined code runs", {26'd0, mode_rd}, 32'h2A);

    // R3: enabled-wake sleep ignores disabled lines
    step(1'b1, wr_word(6'h09), '0, '0);
    check("R3 cpu gated", {31'd0, cpu_clk_en}, 32'd0);
    step(1'b0, '0, 16'h00F0, 16'h0F00);
    check("R3 disabled irq ignored", {31'd0, cpu_clk_en}, 32'd0);
    // R8: write while sleeping ignored
    step(1'b1, wr_word(6'h1A), '0, '0);
    check("R8 write in sleep ignored", {26'd0, mode_rd}, 32'h09);
    step(1'b0, '0, 16'h0100, 16'h0100);
    check("R5 wake mode cleared", {26'd0, mode_rd}, 32'h00);
    check("R5 wake cpu on", {31'd0, cpu_clk_en}, 32'd1);

    // R4: any-wake sleep wakes on disabled line
    step(1'b1, wr_word(6'h11), '0, '0);
    step(1'b0, '0, 16'h8000, 16'h0000);
    check("R4 any irq wakes", {31'd0, cpu_clk_en}, 32'd1);

    // R6 / R9: output halt
    step(1'b1, wr_word(6'h1A), '0, '0);
    check("R9 hold in deep", {31'd0, io_hold}, 32'd1);
    step(1'b1, wr_word(6'h00), 16'hFFFF, 16'hFFFF);
    check("R6 irq and write ignored", {31'd0, pll_out_en}, 32'd0);

    // R7: reference stop, exit by reset with relock
    do_reset(12'd2);
    for (int i = 0; i < 5; i++) step(1'b0, '0, '0, '0);
    step(1'b1, wr_word(6'h1C), '0, '0);
    check("R7 reference off", {31'd0, pll_ref_en}, 32'd0);
    step(1'b0, '0, 16'h0001, 16'h0001);
    check("R7 stays off", {31'd0, pll_ref_en}, 32'd0);
    do_reset(12'd0);
    step(1'b0, '0, '0, '0);
    step(1'b0, '0, '0, '0);
    check("R7 relock after deep reset", {31'd0, clk_rel}, 32'd0);
    step(1'b0, '0, '0, '0);
    check("R7 released", {31'd0, clk_rel}, 32'd1);

    // random phase
    for (int blk = 0; blk < 60; blk++) begin
      int deep_cycles;
      do_reset(12'($urandom_range(0, 15)));
      deep_cycles = 0;
      for (int c = 0; c < 60; c++) begin
        logic              wr;
        logic [5:0]        code;
        logic [IRQ_W-1:0]  p, e;
        int sel;
        wr  = ($urandom_range(0, 3) == 0);
        sel = $urandom_range(0, 11);
        case (sel)
          0, 1, 2: code = 6'h09;
          3, 4, 5: code = 6'h11;
          6:       code = 6'h1A;
          7:       code = 6'h1C;
          8:       code = 6'h00;
          default: code = 6'($urandom);
        endcase
        p = ($urandom_range(0, 3) == 0) ? IRQ_W'($urandom) & IRQ_W'($urandom) : '0;
        e = IRQ_W'($urandom);
        step(wr, wr_word(code), p, e);
        if (m_st == M_DOUT || m_st == M_DREF) deep_cycles++;
        if (deep_cycles > 5) break;
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule